// File: doc/BRIEF.md
# Programmable Memory Pattern Dispatcher

This block picks which micro-pattern a memory controller runs and then walks it. The patterns live in a 64-word writable pattern RAM inside the block. Six kinds of request can start a pattern:

- a single-beat read from a bus master
- a burst read from a bus master
- a single-beat write from a bus master
- a burst write from a bus master
- a periodic refresh-timer tick
- an exception event

Each kind starts at its own fixed word. A software RUN command can also start a pattern at any word, using an index it supplies. Once a pattern starts, the block moves to the next word on every clock. It shows the current index and word, and raises a per-beat acknowledge for each word that carries the acknowledge bit.

A pattern ends in one of two ways. It ends on a word that carries the last bit. A master access can also end when it has collected the acknowledges it needs: one for a single beat, and for a burst a number set by the port width.

An exception does not wait. It aborts whatever is running and starts the exception pattern on the next clock. Timer, RUN and master requests are latched as pending. They are granted one at a time, only while the block is not busy. Software fills the pattern RAM through a synchronous write port before it issues requests. Decoding the pattern word into pin timing is left to the logic downstream.

Top module: `mem_pattern_dispatcher`

## Requirements
- R1: Each master access type starts at a fixed RAM index:
  - read single-beat at 0x00
  - read burst at 0x08
  - write single-beat at 0x18
  - write burst at 0x20

  The periodic timer starts at 0x30 and the exception pattern at 0x3C. A timer, RUN or master request pulse makes its first index visible on `ram_index` two cycles after the pulse. An exception makes it visible one cycle after.
- R2: A RUN command starts its pattern at `run_index`, for every value 0x00 to 0x3F.
- R3: While a pattern runs and is not ending, `ram_index` rises by one each clock and wraps from 0x3F to 0x00. `pat_word` always holds the RAM word at `ram_index`.
- R4: In a pattern word, bit 0 is the acknowledge bit and bit 1 is the last bit. `beat_ack` is high in each running cycle whose word has bit 0 set. `done` is high in the running cycle whose word has bit 1 set.
- R5: A single-beat master access (`mst_burst`=0) ends, with `done` high, in the cycle of its first acknowledged word, unless a last bit comes first.
- R6: A burst master access ends in the cycle of its Nth acknowledge. N is 4 when `port_width` is 00 (32-bit), 8 when it is 01 (16-bit), 16 when it is 10 (8-bit) and 4 when it is 11. `port_width` is sampled when the burst is granted.
- R7: Timer, exception and RUN patterns have no acknowledge limit. They end only on a word with the last bit.
- R8: An exception request during a running pattern aborts it. The next cycle shows index 0x3C with `busy` high. The aborted pattern raises no further `done`. This also holds when the exception arrives in the cycle the running pattern ends.
- R9: Pending requests are granted in priority order: exception first, then timer, then RUN, then master. Requests that lose stay pending and run later, each after the previous pattern has finished.
- R10: `busy` is high from the first running cycle through the cycle after `done`. Timer, RUN and master requests are not granted while `busy` is high.
- R11: A RAM write (`wr_en`) takes effect only when `busy` is low. A write issued while busy is ignored.
- R12: After reset, `busy`, `done` and `beat_ack` are low and `ram_index` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_req | input | 1 | Master access request pulse |
| mst_write | input | 1 | Master access is a write |
| mst_burst | input | 1 | Master access is a burst |
| port_width | input | 2 | Port width code: 00 32-bit, 01 16-bit, 10 8-bit, 11 32-bit |
| tmr_req | input | 1 | Periodic timer request pulse |
| exc_req | input | 1 | Exception request (preempts) |
| run_req | input | 1 | Software RUN command pulse |
| run_index | input | 6 | Start index for the RUN command |
| wr_en | input | 1 | Pattern RAM write enable |
| wr_addr | input | 6 | Pattern RAM write address |
| wr_data | input | 8 | Pattern RAM write data |
| ram_index | output | 6 | Current pattern RAM index |
| pat_word | output | 8 | Pattern word at `ram_index` |
| beat_ack | output | 1 | Transfer acknowledge for this beat |
| done | output | 1 | Pattern ends this cycle |
| busy | output | 1 | A pattern is running or just finished |

## Verification
Two functions can fall in the same cycle: an exception preemption and the normal end of the running pattern. The bench starts a single-beat read and drives the exception in the cycle that reaches its acknowledged word. It expects `done` high in that cycle and 0x3C with no tail cycle in the next one. Burst writes are also aborted at each of their first four cycles, and every cycle is compared against an index walk computed in the bench. A second overlap puts all four request sources in one cycle. That run is judged by the order of the start indices seen, and by `busy` dropping for a cycle between each pattern.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

  // Fixed start words of each pattern kind
  localparam int unsigned START_RD_SINGLE = 'h00;
  localparam int unsigned START_RD_BURST  = 'h08;
  localparam int unsigned START_WR_SINGLE = 'h18;
  localparam int unsigned START_WR_BURST  = 'h20;
  localparam int unsigned START_TIMER     = 'h30;
  localparam int unsigned START_EXCEPT    = 'h3C;

  typedef enum logic [1:0] {
    PW_32   = 2'b00,
    PW_16   = 2'b01,
    PW_8    = 2'b10,
    PW_RSVD = 2'b11
  } port_w_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_EXC,
    SRC_TMR,
    SRC_RUN,
    SRC_MST
  } src_e;

  // Acknowledges needed to move one 32-bit word over the port
  function automatic int unsigned acks_per_word(input port_w_e pw);
    unique case (pw)
      PW_16:   return 2;
      PW_8:    return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/mpd_pattern_ram.sv
module mpd_pattern_ram #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // Simple dual port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mpd_arbiter.sv
module mpd_arbiter
  import mpd_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BURST_WORDS = 4,
  parameter int CNT_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              exc_req,
  input  logic              tmr_req,
  input  logic              run_req,
  input  logic [ADDR_W-1:0] run_index,
  input  logic              mst_req,
  input  logic              mst_write,
  input  logic              mst_burst,
  input  logic [1:0]        port_width,
  output logic              start,
  output logic [ADDR_W-1:0] start_idx,
  output logic              start_lim_en,
  output logic [CNT_W-1:0]  start_lim
);

  localparam int NSRC  = 3;
  localparam int P_TMR = 0;
  localparam int P_RUN = 1;
  localparam int P_MST = 2;

  logic [NSRC-1:0]   req_vec;
  logic [NSRC-1:0]   pend_q;
  logic [NSRC-1:0]   grant;
  logic [ADDR_W-1:0] run_idx_q;
  logic              mst_wr_q;
  logic              mst_bu_q;
  src_e              sel;

  assign req_vec = {mst_req, run_req, tmr_req};

  // Fixed priority: exception regardless of busy, others only when idle
  always_comb begin
    sel = SRC_NONE;
    if (exc_req)                sel = SRC_EXC;
    else if (!busy) begin
      if (pend_q[P_TMR])        sel = SRC_TMR;
      else if (pend_q[P_RUN])   sel = SRC_RUN;
      else if (pend_q[P_MST])   sel = SRC_MST;
    end
  end

  assign grant = {sel == SRC_MST, sel == SRC_RUN, sel == SRC_TMR};
  assign start = (sel != SRC_NONE);

  always_comb begin
    start_idx    = '0;
    start_lim_en = 1'b0;
    start_lim    = CNT_W'(1);
    unique case (sel)
      SRC_EXC: start_idx = ADDR_W'(START_EXCEPT);
      SRC_TMR: start_idx = ADDR_W'(START_TIMER);
      SRC_RUN: start_idx = run_idx_q;
      SRC_MST: begin
        start_lim_en = 1'b1;
        unique case ({mst_wr_q, mst_bu_q})
          2'b00:   start_idx = ADDR_W'(START_RD_SINGLE);
          2'b01:   start_idx = ADDR_W'(START_RD_BURST);
          2'b10:   start_idx = ADDR_W'(START_WR_SINGLE);
          default: start_idx = ADDR_W'(START_WR_BURST);
        endcase
        if (mst_bu_q)
          start_lim = CNT_W'(BURST_WORDS * acks_per_word(port_w_e'(port_width)));
      end
      default: start_idx = '0;
    endcase
  end

  // Pending flags: a new pulse sets, a grant clears
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      run_idx_q <= '0;
      mst_wr_q  <= 1'b0;
      mst_bu_q  <= 1'b0;
    end else begin
      for (int s = 0; s < NSRC; s++)
        pend_q[s] <= req_vec[s] | (pend_q[s] & ~grant[s]);
      if (run_req && (!pend_q[P_RUN] || grant[P_RUN]))
        run_idx_q <= run_index;
      if (mst_req && (!pend_q[P_MST] || grant[P_MST])) begin
        mst_wr_q <= mst_write;
        mst_bu_q <= mst_burst;
      end
    end
  end

  // R9
  idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> (!busy && !exc_req));

  // R10
  mst_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q[P_MST] && busy && !exc_req) |=> pend_q[P_MST]);

endmodule

// File: rtl/mpd_sequencer.sv
module mpd_sequencer #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_idx,
  input  logic              start_lim_en,
  input  logic [CNT_W-1:0]  start_lim,
  input  logic              word_ack,
  input  logic              word_last,
  output logic [ADDR_W-1:0] idx_next,
  output logic [ADDR_W-1:0] index,
  output logic              beat_ack,
  output logic              done,
  output logic              busy
);

  logic              active_q;
  logic              tail_q;
  logic              lim_en_q;
  logic [CNT_W-1:0]  lim_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] idx_r;
  logic              lim_hit;

  assign beat_ack = active_q & word_ack;
  assign lim_hit  = lim_en_q & beat_ack & ((cnt_q + CNT_W'(1)) == lim_q);
  assign done     = active_q & (word_last | lim_hit);
  assign busy     = active_q | tail_q;
  assign index    = idx_r;

  always_comb begin
    if (start)                idx_next = start_idx;
    else if (active_q && !done) idx_next = idx_r + ADDR_W'(1);
    else                      idx_next = idx_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      tail_q   <= 1'b0;
      lim_en_q <= 1'b0;
      lim_q    <= '0;
      cnt_q    <= '0;
      idx_r    <= '0;
    end else begin
      idx_r  <= idx_next;
      tail_q <= done & ~start;
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        lim_en_q <= start_lim_en;
        lim_q    <= start_lim;
      end else if (done) begin
        active_q <= 1'b0;
      end else if (beat_ack) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && !done && !start) |=> (idx_r == $past(idx_r) + ADDR_W'(1)));

  // R6
  ack_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && lim_en_q) |-> (cnt_q < lim_q));

  // R10
  tail_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (busy && !active_q && !done));

endmodule

// File: rtl/mem_pattern_dispatcher.sv
module mem_pattern_dispatcher
  import mpd_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int WORD_W      = 8,
  parameter int BURST_WORDS = 4,
  parameter int ACK_BIT     = 0,
  parameter int LAST_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mst_req,
  input  logic              mst_write,
  input  logic              mst_burst,
  input  logic [1:0]        port_width,
  input  logic              tmr_req,
  input  logic              exc_req,
  input  logic              run_req,
  input  logic [ADDR_W-1:0] run_index,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [ADDR_W-1:0] ram_index,
  output logic [WORD_W-1:0] pat_word,
  output logic              beat_ack,
  output logic              done,
  output logic              busy
);

  localparam int CNT_W = $clog2(BURST_WORDS * 4 + 1);

  logic              start;
  logic [ADDR_W-1:0] start_idx;
  logic              start_lim_en;
  logic [CNT_W-1:0]  start_lim;
  logic [ADDR_W-1:0] idx_next;
  logic              ram_we;

  assign ram_we = wr_en & ~busy;

  mpd_arbiter #(
    .ADDR_W(ADDR_W), .BURST_WORDS(BURST_WORDS), .CNT_W(CNT_W)
  ) arb_i (
    .clk(clk), .rst(rst), .busy(busy),
    .exc_req(exc_req), .tmr_req(tmr_req),
    .run_req(run_req), .run_index(run_index),
    .mst_req(mst_req), .mst_write(mst_write), .mst_burst(mst_burst),
    .port_width(port_width),
    .start(start), .start_idx(start_idx),
    .start_lim_en(start_lim_en), .start_lim(start_lim)
  );

  mpd_sequencer #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) seq_i (
    .clk(clk), .rst(rst),
    .start(start), .start_idx(start_idx),
    .start_lim_en(start_lim_en), .start_lim(start_lim),
    .word_ack(pat_word[ACK_BIT]), .word_last(pat_word[LAST_BIT]),
    .idx_next(idx_next), .index(ram_index),
    .beat_ack(beat_ack), .done(done), .busy(busy)
  );

  mpd_pattern_ram #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) ram_i (
    .clk(clk), .we(ram_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(idx_next), .rdata(pat_word)
  );

  // R8
  exc_start_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> (ram_index == ADDR_W'(START_EXCEPT) && busy));

  // R12
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !beat_ack && ram_index == '0));

endmodule

// File: tb/mem_pattern_dispatcher_tb_top.sv
module mem_pattern_dispatcher_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mst_req = 0, mst_write = 0, mst_burst = 0;
  logic [1:0] port_width = 2'b00;
  logic       tmr_req = 0, exc_req = 0, run_req = 0;
  logic [5:0] run_index = '0;
  logic       wr_en = 0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] ram_index;
  logic [7:0] pat_word;
  logic       beat_ack, done, busy;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] model [64];

  always #5 clk = ~clk;

  mem_pattern_dispatcher dut_i (
    .clk(clk), .rst(rst),
    .mst_req(mst_req), .mst_write(mst_write), .mst_burst(mst_burst),
    .port_width(port_width),
    .tmr_req(tmr_req), .exc_req(exc_req),
    .run_req(run_req), .run_index(run_index),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ram_index(ram_index), .pat_word(pat_word),
    .beat_ack(beat_ack), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Word layout: bits 7:2 = own index, bit 1 = last, bit 0 = ack
  function automatic logic [7:0] init_word(input int i);
    logic a, l;
    a = (i % 4) != 0;
    l = (i == 'h06) || (i == 'h35) || (i == 'h3E);
    return {i[5:0], l, a};
  endfunction

  function automatic int burst_need(input logic [1:0] pw);
    return 4 * ((pw == 2'b01) ? 2 : (pw == 2'b10) ? 4 : 1);
  endfunction

  // Entered at the negedge where the first word is visible.
  // abort_at >= 0: drive an exception after checking that cycle.
  // inj_wr: hold wr_en high during cycle 0 of the run.
  task automatic expect_pattern(input int start, input bit lim_en, input int lim,
                                input int abort_at, input bit inj_wr, input string tag);
    int idx = start;
    int cnt = 0;
    for (int j = 0; j < 200; j++) begin
      bit a = model[idx][0];
      bit l = model[idx][1];
      bit d = l || (lim_en && a && (cnt + 1 == lim));
      chk(ram_index == idx[5:0], {tag, " index"}, ram_index, idx);
      chk(pat_word == model[idx], {tag, " word (R3)"}, pat_word, model[idx]);
      chk(beat_ack == a, {tag, " beat_ack (R4)"}, beat_ack, a);
      chk(done == d, {tag, " done"}, done, d);
      chk(busy == 1'b1, {tag, " busy (R10)"}, busy, 1);
      if (inj_wr) wr_en = (j == 0);
      if (j == abort_at) begin
        exc_req = 1'b1;
        @(negedge clk);
        exc_req = 1'b0;
        return;
      end
      if (d) begin
        @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0, {tag, " tail (R10)"}, {busy, done}, 2'b10);
        @(negedge clk);
        chk(busy == 1'b0, {tag, " idle after tail (R10)"}, busy, 0);
        return;
      end
      if (a) cnt++;
      idx = (idx + 1) % 64;
      @(negedge clk);
    end
    chk(1'b0, {tag, " pattern never ended"}, 0, 1);
  endtask

  task automatic req_master(input bit w, input bit b);
    mst_write = w; mst_burst = b; mst_req = 1'b1;
    @(negedge clk); mst_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic req_run(input int s);
    run_index = s[5:0]; run_req = 1'b1;
    @(negedge clk); run_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic req_timer();
    tmr_req = 1'b1;
    @(negedge clk); tmr_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic req_exc();
    exc_req = 1'b1;
    @(negedge clk); exc_req = 1'b0;
  endtask

  task automatic ram_write(input int a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a[5:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !beat_ack, "R12 flags in reset", {busy, done, beat_ack}, 0);
    chk(ram_index == 6'd0, "R12 index in reset", ram_index, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && ram_index == 6'd0, "R12 after release", {busy, done}, 0);

    // R11 load while idle
    for (int i = 0; i < 64; i++) ram_write(i, init_word(i));
    @(negedge clk);
    chk(pat_word == model[0], "R11 idle write visible", pat_word, model[0]);

    // R1/R5 single-beat accesses
    req_master(1'b0, 1'b0);
    expect_pattern('h00, 1, 1, -1, 0, "R1/R5 read single");
    req_master(1'b1, 1'b0);
    expect_pattern('h18, 1, 1, -1, 0, "R1/R5 write single");

    // R1/R6 bursts, all port width codes
    for (int pw = 0; pw < 4; pw++) begin
      port_width = pw[1:0];
      req_master(1'b0, 1'b1);
      expect_pattern('h08, 1, burst_need(pw[1:0]), -1, 0, "R1/R6 read burst");
      req_master(1'b1, 1'b1);
      expect_pattern('h20, 1, burst_need(pw[1:0]), -1, 0, "R1/R6 write burst");
    end

    // R1/R7 timer and exception from idle
    req_timer();
    expect_pattern('h30, 0, 0, -1, 0, "R1/R7 timer");
    req_exc();
    expect_pattern('h3C, 0, 0, -1, 0, "R1/R7 exception");

    // R2/R7 RUN at every index, including wrap past 0x3F (R3)
    for (int s = 0; s < 64; s++) begin
      req_run(s);
      expect_pattern(s, 0, 0, -1, 0, "R2/R7 RUN");
    end

    // R8 preemption of a burst at several points
    port_width = 2'b10;
    for (int k = 0; k < 4; k++) begin
      req_master(1'b1, 1'b1);
      expect_pattern('h20, 1, 16, k, 0, "R8 preempted burst");
      expect_pattern('h3C, 0, 0, -1, 0, "R8 exception after abort");
    end
    // R8 exception in the very cycle the single read ends (index 0x01)
    req_master(1'b0, 1'b0);
    expect_pattern('h00, 1, 1, 1, 0, "R8 coincident end");
    expect_pattern('h3C, 0, 0, -1, 0, "R8 exception after coincident end");

    // R9/R10 all sources in one cycle
    run_index = 6'h3A; mst_write = 1'b1; mst_burst = 1'b0;
    exc_req = 1; tmr_req = 1; run_req = 1; mst_req = 1;
    @(negedge clk);
    exc_req = 0; tmr_req = 0; run_req = 0; mst_req = 0;
    expect_pattern('h3C, 0, 0, -1, 0, "R9 first exception");
    @(negedge clk);
    expect_pattern('h30, 0, 0, -1, 0, "R9 second timer");
    @(negedge clk);
    expect_pattern('h3A, 0, 0, -1, 0, "R9 third RUN");
    @(negedge clk);
    expect_pattern('h18, 1, 1, -1, 0, "R9 fourth master");
    @(negedge clk);
    chk(busy == 1'b0, "R9 nothing left pending", busy, 0);

    // R11 write during a run is ignored (would put last at 0x0A)
    wr_addr = 6'h0A; wr_data = 8'hFF;
    req_run('h2A);
    expect_pattern('h2A, 0, 0, -1, 1, "R11 run with blocked write");
    req_run('h0A);
    expect_pattern('h0A, 0, 0, -1, 0, "R11 word unchanged");
    port_width = 2'b10;
    req_master(1'b0, 1'b1);
    expect_pattern('h08, 1, 16, -1, 0, "R11 burst across 0x0A");

    // R11 idle write takes effect: exception now ends at 0x3D
    ram_write('h3D, {6'h3D, 2'b11});
    req_exc();
    expect_pattern('h3C, 0, 0, -1, 0, "R11 idle write used");
    ram_write('h3D, init_word('h3D));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule